// File: doc/BRIEF.md
# Port-Mapped I/O Decoder

This block sits on the processor's separate I/O address space and provides one byte-wide output latch and one byte-wide input buffer. A cycle targets I/O space when the active-low I/O-request strobe is low. In that case the low eight address bits carry a port number, so up to 256 input and 256 output ports are possible. The block answers to two of those numbers, one for writing and one for reading. Both numbers are parameters, with defaults of 03h for the output port and 02h for the input port.

On a write to its output port, the latch takes the data bus value at the next clock edge. It then holds that byte on its output pins until another write to that port, so the pins stay fixed through memory cycles and accesses to other ports. On a read of its input port, the buffer places the external input pins on the data bus and raises its bus output-enable in the same cycle. In every other cycle the enable is low and the block's bus output is zero, so the block never competes with memory or with other devices on a read. Because both the strobes and the data bus are plain level signals, the block has no handshake.

Top module: `io_port_decoder`

## Requirements
- R1: After reset, the output pins read 00h, the bus output-enable is 0 and the bus output is 00h.
- R2: In a cycle with the I/O-request strobe low, the write strobe low and address bits 7:0 equal to the output port number, the data bus is loaded into the latch at the clock edge. The output pins show the new byte from that edge on.
- R3: When the I/O-request strobe is high, a write strobe does not change the output pins, whatever the address holds (memory cycle).
- R4: A write strobe with a port number other than the output port leaves the output pins unchanged. This includes the input port number (02h by default).
- R5: Address bits above bit 7 take no part in decoding. A write to output port 03h with any upper address byte loads the latch, and a read of input port 02h with any upper byte drives the bus.
- R6: In a cycle with the I/O-request strobe low, the read strobe low and address bits 7:0 equal to the input port number, the bus output-enable is 1 and the bus output equals the input pins in that same cycle, with no clock delay.
- R7: In every other cycle the bus output-enable is 0 and the bus output is 00h. This covers memory reads (I/O-request high) and reads of any other port number, including the output port 03h.
- R8: The latched byte persists across any number of cycles that do not load it, including reads of the input port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus; only bits 7:0 are decoded |
| iorq_n | input | 1 | Active-low I/O-request strobe |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bus_wdata | input | 8 | Data bus as driven by the processor |
| bus_rdata | output | 8 | Data returned to the processor; 00h when not driving |
| bus_rdata_oe | output | 1 | High while the block drives the data bus |
| port_out | output | 8 | Output latch value on external pins |
| port_in | input | 8 | External input pins |

## Verification
A latch update and an input-buffer read can be in flight in the same cycle. In the cycle straight after a write to port 03h, the bench reads port 02h while changing the input pins. It then judges that the bus carries the current input pins, that the output pins already show the newly written byte, and that the byte does not change during the read. The bench also uses each port number with the other port's strobe, and repeats accesses with arbitrary upper address bytes and with the I/O-request strobe high. In each case it confirms that only the decoded path responds.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned DATA_W = 8;
  typedef logic [PORT_W-1:0] port_num_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef enum logic [1:0] {
    IO_IDLE  = 2'b00,
    IO_READ  = 2'b01,
    IO_WRITE = 2'b10
  } io_kind_e;
endpackage

// File: rtl/io_port_match.sv
module io_port_match #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PORT_W = 8,
  parameter logic [PORT_W-1:0] PORT_NUM = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned HI_W = ADDR_W - PORT_W;
  logic [PORT_W-1:0] bit_eq;
  logic unused_hi;

  genvar g;
  generate
    for (g = 0; g < PORT_W; g++) begin : g_cmp
      assign bit_eq[g] = ~(addr[g] ^ PORT_NUM[g]);
    end
    if (HI_W > 0) begin : g_hi
      assign unused_hi = ^addr[ADDR_W-1:PORT_W];
    end else begin : g_nohi
      assign unused_hi = 1'b0;
    end
  endgenerate

  assign hit = &bit_eq;
endmodule

// File: rtl/io_out_latch.sv
module io_out_latch
  import io_dec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  data_t d,
  output data_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= d;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/io_in_buffer.sv
module io_in_buffer
  import io_dec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel,
  input  data_t pins,
  output data_t dout,
  output logic  oe
);
  assign oe   = sel;
  assign dout = sel ? pins : '0;

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (dout == '0));
  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (dout == pins));
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import io_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [7:0] OUT_PORT = 8'h03,
  parameter logic [7:0] IN_PORT  = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rdata_oe,
  output logic [7:0]        port_out,
  input  logic [7:0]        port_in
);
  logic hit_out, hit_in;
  io_kind_e kind;

  io_port_match #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .PORT_NUM(OUT_PORT)) u_match_out (
    .addr(addr), .hit(hit_out));
  io_port_match #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .PORT_NUM(IN_PORT)) u_match_in (
    .addr(addr), .hit(hit_in));

  always_comb begin
    kind = IO_IDLE;
    if (!iorq_n && !wr_n)      kind = IO_WRITE;
    else if (!iorq_n && !rd_n) kind = IO_READ;
  end

  io_out_latch u_latch (
    .clk(clk), .rst_n(rst_n),
    .load(hit_out && (kind == IO_WRITE)),
    .d(bus_wdata), .q(port_out));

  io_in_buffer u_inbuf (
    .clk(clk), .rst_n(rst_n),
    .sel(hit_in && (kind == IO_READ)),
    .pins(port_in), .dout(bus_rdata), .oe(bus_rdata_oe));

  p_memcyc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iorq_n |=> $stable(port_out));
  p_oe_io_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> (!iorq_n && !rd_n));
  p_other_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[7:0] != OUT_PORT) |=> $stable(port_out));
endmodule

// File: tb/sim_io_port_decoder.sv
module sim_io_port_decoder;
  logic clk = 0, rst_n = 0;
  logic [15:0] addr = 16'h0;
  logic iorq_n = 1, rd_n = 1, wr_n = 1;
  logic [7:0] bus_wdata = 8'h0, port_in = 8'h0;
  logic [7:0] bus_rdata, port_out;
  logic bus_rdata_oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  io_port_decoder u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .port_out(port_out), .port_in(port_in));

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [15:0] a, input logic io, input logic rd,
                     input logic wr, input logic [7:0] d);
    @(negedge clk);
    addr = a; iorq_n = ~io; rd_n = ~rd; wr_n = ~wr; bus_wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    iorq_n = 1; rd_n = 1; wr_n = 1;
  endtask

  task automatic t_reset();
    chk("R1 pins", {1'b0, port_out}, 9'h000);
    chk("R1 oe/data", {bus_rdata_oe, bus_rdata}, 9'h000);
  endtask

  task automatic t_write();
    cyc(16'h0003, 1, 0, 1, 8'hA5); idle();
    chk("R2 load", {1'b0, port_out}, 9'h0A5);
    cyc(16'h0003, 1, 0, 1, 8'h3C); idle();
    chk("R2 reload", {1'b0, port_out}, 9'h03C);
  endtask

  task automatic t_memwrite();
    cyc(16'h0003, 0, 0, 1, 8'hFF); idle();
    chk("R3 mem write", {1'b0, port_out}, 9'h03C);
    cyc(16'hAB03, 0, 0, 1, 8'h11); idle();
    chk("R3 mem write hi", {1'b0, port_out}, 9'h03C);
  endtask

  task automatic t_otherport();
    cyc(16'h0002, 1, 0, 1, 8'h77); idle();
    chk("R4 in-port num", {1'b0, port_out}, 9'h03C);
    cyc(16'h0083, 1, 0, 1, 8'h77); idle();
    chk("R4 bit7 differs", {1'b0, port_out}, 9'h03C);
  endtask

  task automatic t_upper();
    cyc(16'hFF03, 1, 0, 1, 8'h5A); idle();
    chk("R5 write hi byte", {1'b0, port_out}, 9'h05A);
    port_in = 8'hC3;
    cyc(16'h7E02, 1, 1, 0, 8'h00);
    chk("R5 read hi byte", {bus_rdata_oe, bus_rdata}, 9'h1C3);
    idle();
  endtask

  task automatic t_read();
    port_in = 8'h96;
    cyc(16'h0002, 1, 1, 0, 8'h00);
    chk("R6 read", {bus_rdata_oe, bus_rdata}, 9'h196);
    port_in = 8'h4B; #1;
    chk("R6 same cycle", {bus_rdata_oe, bus_rdata}, 9'h14B);
    idle(); #1;
    chk("R7 after read", {bus_rdata_oe, bus_rdata}, 9'h000);
  endtask

  task automatic t_noread();
    port_in = 8'hEE;
    cyc(16'h0002, 0, 1, 0, 8'h00);
    chk("R7 memory read", {bus_rdata_oe, bus_rdata}, 9'h000);
    cyc(16'h0003, 1, 1, 0, 8'h00);
    chk("R7 out-port read", {bus_rdata_oe, bus_rdata}, 9'h000);
    cyc(16'h0042, 1, 1, 0, 8'h00);
    chk("R7 other port", {bus_rdata_oe, bus_rdata}, 9'h000);
    idle();
  endtask

  task automatic t_overlap();
    cyc(16'h0003, 1, 0, 1, 8'hD2);
    port_in = 8'h19;
    cyc(16'h0002, 1, 1, 0, 8'h00);
    chk("R8 new byte at read", {1'b0, port_out}, 9'h0D2);
    chk("R6 read after write", {bus_rdata_oe, bus_rdata}, 9'h119);
    idle();
    for (int i = 0; i < 6; i++) cyc(16'h1200 + 16'(i), i[0], 1, 0, 8'h00);
    idle();
    chk("R8 held", {1'b0, port_out}, 9'h0D2);
  endtask

  initial begin
    #20000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #12;
    t_reset();
    @(negedge clk); rst_n = 1;
    t_reset();
    t_write();
    t_memwrite();
    t_otherport();
    t_upper();
    t_read();
    t_noread();
    t_overlap();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule